// File: doc/BRIEF.md
# Segment Selector Load Unit

This unit carries out the load of a 16-bit selector into one of six segment registers (code, stack and four data registers) or into the local-table register. A load request gives the selector and a target code. The unit splits the selector into an index, a table flag and a requested privilege level. It chooses either the global table, whose base and limit arrive as inputs, or the local table, whose base and limit come from the local-table register's own cached descriptor. It checks that the whole 8-byte entry lies inside the table limit, then fetches the entry over a 64-bit memory port that takes one request at a time.

After the fetch, the unit checks the descriptor's kind and present flag against the target register. It sets the accessed flag of a user descriptor in memory and writes the cached base, expanded limit and attributes for the target. A load into the code register also sets the current privilege level. A failed load reports a protection fault or a not-present fault together with the offending selector, and it changes nothing.

The cached state of any register can be read back through a registered read port selected by `rd_target`.

Top module: `seg_load_unit`

## Requirements
- R1: Selector bits 15:3 are the index, bit 2 the table flag (0 = global, 1 = local), and bits 1:0 the requested privilege. The entry is read at the table base plus index times 8. A successful load stores the full selector as the register's visible value.
- R2: If index*8+7 exceeds the table limit, the load faults with code 1 and makes no memory access. The global limit is the 16-bit `gdt_limit`. The local limit is the cached 32-bit limit of the local-table register.
- R3: A null selector (index 0, table flag 0, any privilege bits) loaded into a data register (targets 2 to 5) or the local-table register (target 6) makes no memory access. It stores the selector and marks the register unusable (`rd_valid`=0).
- R4: A null selector loaded into the code register (target 0) faults with code 1. A null selector loaded into the stack register (target 1) faults with code 1 unless `long_mode`=1 and the current privilege is not 3.
- R5: With table flag 1, index 0 selects the first local entry and is not null. A table-flag-1 selector faults with code 1 while the local-table register is unusable, and whenever the target is the local-table register itself.
- R6: Type checks per target, using descriptor bit 44 (S) and bits 43:40 (type). Code register: S=1 and type bit 3 = 1. Stack register: S=1, type bit 3 = 0 and type bit 1 = 1. Data registers: S=1 and (type bit 3 = 0 or type bit 1 = 1). Local-table register: S=0 and type = 0010. Target code 7 is invalid. Any failure faults with code 1.
- R7: A descriptor that passes its type check but has bit 47 (present) clear faults with code 2.
- R8: On a successful load of a user descriptor (S=1) whose bit 40 is 0, the same 64-bit value with bit 40 set is written back to the entry address. If bit 40 is already 1, or the target is the local-table register, no write occurs.
- R9: The cached base is {d[63:56], d[39:32], d[31:16]}. The 20-bit limit {d[51:48], d[15:0]} is stored as-is when d[55]=0, and as limit*4096+4095 when d[55]=1. The 12-bit attribute is {d[55:52], d[47:44], d[43:41], d[40] or S}. `rd_valid`=1.
- R10: A successful non-null load into the code register sets `cpl` to descriptor bits 46:45. Reset sets `cpl` to 0.
- R11: A fault leaves every register's selector, cache and `cpl` unchanged. `fault` pulses together with `done`, and `fault_code`/`fault_sel` hold the code and selector until the next accepted start.
- R12: `busy` rises the cycle after an accepted `start` and falls with the one-cycle `done` pulse. `start` is ignored while busy. `mem_req` holds with a stable address and direction until `mem_ready`.
- R13: After reset every register is unusable with selector 0, `busy`, `done` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load request pulse |
| sel_in | input | 16 | Selector to load |
| target | input | 3 | 0 code, 1 stack, 2..5 data, 6 local table |
| long_mode | input | 1 | 64-bit mode indication |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_limit | input | 16 | Global table limit in bytes |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion was a fault |
| fault_code | output | 2 | 0 none, 1 protection, 2 not present |
| fault_sel | output | 16 | Selector that faulted |
| cpl | output | 2 | Current privilege level |
| rd_target | input | 3 | Register to read back |
| rd_valid | output | 1 | Register usable |
| rd_sel | output | 16 | Visible selector |
| rd_base | output | 32 | Cached base |
| rd_limit | output | 32 | Cached expanded limit |
| rd_attr | output | 12 | Cached attributes |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Memory accepts / read data valid |
| mem_rdata | input | 64 | Read data |

## Verification
The load path is driven with selectors that differ in one aspect at a time. A null selector is aimed at each kind of target, which separates permitted unusable loads from faults. Table-flag-1 selectors are tried before and after a local table exists, which tells the local-table lookup apart from the global one. Indexes just inside and just outside each limit show whether a memory access took place. Descriptors of every kind (code, read-only, writable, already accessed, not present, local-table) are sent to matching and mismatching targets, so a type fault, a not-present fault, a plain load and a load with write-back each give a different result in the cache, in the memory and in the write count.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int NREG = 7;
  localparam logic [2:0] TGT_CS   = 3'd0;
  localparam logic [2:0] TGT_SS   = 3'd1;
  localparam logic [2:0] TGT_DS   = 3'd2;
  localparam logic [2:0] TGT_GS   = 3'd5;
  localparam logic [2:0] TGT_LDTR = 3'd6;
  localparam logic [1:0] FC_NONE  = 2'd0;
  localparam logic [1:0] FC_GP    = 2'd1;
  localparam logic [1:0] FC_NP    = 2'd2;

  typedef struct packed {
    logic        valid;
    logic [15:0] sel;
    logic [31:0] base;
    logic [31:0] limit;
    logic [11:0] attr;
  } seg_cache_t;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [15:0]       sel,
  input  logic [2:0]        tgt,
  input  logic              long_mode,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [15:0]       gdt_limit,
  input  logic              ldt_valid,
  input  logic [31:0]       ldt_base,
  input  logic [31:0]       ldt_limit,
  output logic              is_null,
  output logic              null_ok,
  output logic              pre_gp,
  output logic [ADDR_W-1:0] entry_addr
);
  logic [12:0] index;
  logic        ti;
  logic [15:0] last_byte;
  logic [15:0] first_byte;
  logic        oob;
  logic        bad_tgt;

  assign index      = sel[15:3];
  assign ti         = sel[2];
  assign last_byte  = {index, 3'b111};
  assign first_byte = {index, 3'b000};
  assign is_null    = (index == '0) && !ti;
  assign bad_tgt    = (tgt > TGT_LDTR);

  always_comb begin
    case (tgt)
      TGT_CS:  null_ok = 1'b0;
      TGT_SS:  null_ok = long_mode && (cpl != 2'd3);
      default: null_ok = !bad_tgt;
    endcase
  end

  assign oob = ti ? ({16'b0, last_byte} > ldt_limit) : (last_byte > gdt_limit);
  assign pre_gp = bad_tgt || (ti && (tgt == TGT_LDTR)) || (ti && !ldt_valid) || oob;
  assign entry_addr = (ti ? ADDR_W'(ldt_base) : gdt_base) + ADDR_W'(first_byte);
endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
  import seg_pkg::*;
(
  input  logic [63:0] desc,
  input  logic [2:0]  tgt,
  output logic        type_ok,
  output logic        present,
  output logic        need_wb,
  output logic [31:0] base,
  output logic [31:0] limit,
  output logic [11:0] attr
);
  logic        s_bit;
  logic [3:0]  typ;
  logic [19:0] lim20;

  assign s_bit   = desc[44];
  assign typ     = desc[43:40];
  assign present = desc[47];
  assign lim20   = {desc[51:48], desc[15:0]};

  always_comb begin
    case (tgt)
      TGT_CS:   type_ok = s_bit && typ[3];
      TGT_SS:   type_ok = s_bit && !typ[3] && typ[1];
      TGT_LDTR: type_ok = !s_bit && (typ == 4'b0010);
      default:  type_ok = (tgt <= TGT_GS) && s_bit && (!typ[3] || typ[1]);
    endcase
  end

  assign need_wb = s_bit && !typ[0];
  assign base    = {desc[63:56], desc[39:32], desc[31:16]};
  assign limit   = desc[55] ? {lim20, 12'hFFF} : {12'h000, lim20};
  assign attr    = {desc[55:52], desc[47:44], typ[3:1], typ[0] | s_bit};
endmodule

// File: rtl/seg_cache_file.sv
module seg_cache_file
  import seg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  seg_cache_t wr_data,
  input  logic [2:0] rd_idx,
  output seg_cache_t rd_data,
  output seg_cache_t ldt_ent
);
  seg_cache_t regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    seg_cache_t r_q;
    always_ff @(posedge clk) begin
      if (rst) r_q <= '0;
      else if (wr_en && (wr_idx == 3'(g))) r_q <= wr_data;
    end
    assign regs[g] = r_q;
  end

  assign ldt_ent = regs[TGT_LDTR];

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_idx < 3'(NREG)) rd_data <= regs[rd_idx];
    else rd_data <= '0;
  end

  assert_wr_idx_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx < 3'(NREG)));
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [15:0]       sel_in,
  input  logic [2:0]        target,
  input  logic              long_mode,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [15:0]       gdt_limit,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_code,
  output logic [15:0]       fault_sel,
  output logic [1:0]        cpl,
  input  logic [2:0]        rd_target,
  output logic              rd_valid,
  output logic [15:0]       rd_sel,
  output logic [31:0]       rd_base,
  output logic [31:0]       rd_limit,
  output logic [11:0]       rd_attr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [63:0]       mem_rdata
);
  localparam int ABIT = 40;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_FETCH, ST_EVAL, ST_WB, ST_COMMIT, ST_FAULT
  } state_t;

  state_t            state;
  logic [15:0]       sel_q;
  logic [2:0]        tgt_q;
  logic [63:0]       desc_q;
  logic [ADDR_W-1:0] addr_q;
  seg_cache_t        cdata_q;
  seg_cache_t        rd_data;
  seg_cache_t        ldt_ent;

  logic              is_null, null_ok, pre_gp;
  logic [ADDR_W-1:0] entry_addr;
  logic              type_ok, present, need_wb;
  logic [31:0]       d_base, d_limit;
  logic [11:0]       d_attr;

  seg_sel_decode #(.ADDR_W(ADDR_W)) i_dec (
    .sel(sel_q), .tgt(tgt_q), .long_mode(long_mode), .cpl(cpl),
    .gdt_base(gdt_base), .gdt_limit(gdt_limit),
    .ldt_valid(ldt_ent.valid), .ldt_base(ldt_ent.base), .ldt_limit(ldt_ent.limit),
    .is_null(is_null), .null_ok(null_ok), .pre_gp(pre_gp), .entry_addr(entry_addr)
  );

  seg_desc_check i_chk (
    .desc(desc_q), .tgt(tgt_q), .type_ok(type_ok), .present(present),
    .need_wb(need_wb), .base(d_base), .limit(d_limit), .attr(d_attr)
  );

  seg_cache_file i_cache (
    .clk(clk), .rst(rst), .wr_en(state == ST_COMMIT), .wr_idx(tgt_q),
    .wr_data(cdata_q), .rd_idx(rd_target), .rd_data(rd_data), .ldt_ent(ldt_ent)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sel_q      <= '0;
      tgt_q      <= '0;
      desc_q     <= '0;
      addr_q     <= '0;
      cdata_q    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= FC_NONE;
      fault_sel  <= '0;
      cpl        <= 2'd0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          sel_q      <= sel_in;
          tgt_q      <= target;
          busy       <= 1'b1;
          fault_code <= FC_NONE;
          fault_sel  <= '0;
          state      <= ST_CHECK;
        end
        ST_CHECK: begin
          if (is_null) begin
            if (null_ok) begin
              cdata_q       <= '0;
              cdata_q.sel   <= sel_q;
              state         <= ST_COMMIT;
            end else begin
              fault_code <= FC_GP;
              state      <= ST_FAULT;
            end
          end else if (pre_gp) begin
            fault_code <= FC_GP;
            state      <= ST_FAULT;
          end else begin
            addr_q <= entry_addr;
            state  <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_ready) begin
          desc_q <= mem_rdata;
          state  <= ST_EVAL;
        end
        ST_EVAL: begin
          if (!type_ok) begin
            fault_code <= FC_GP;
            state      <= ST_FAULT;
          end else if (!present) begin
            fault_code <= FC_NP;
            state      <= ST_FAULT;
          end else begin
            cdata_q <= '{valid: 1'b1, sel: sel_q, base: d_base, limit: d_limit, attr: d_attr};
            state   <= (need_wb && (tgt_q != TGT_LDTR)) ? ST_WB : ST_COMMIT;
          end
        end
        ST_WB: if (mem_ready) state <= ST_COMMIT;
        ST_COMMIT: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          if ((tgt_q == TGT_CS) && cdata_q.valid) cpl <= cdata_q.attr[6:5];
          state <= ST_IDLE;
        end
        ST_FAULT: begin
          done      <= 1'b1;
          fault     <= 1'b1;
          busy      <= 1'b0;
          fault_sel <= sel_q;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == ST_FETCH) || (state == ST_WB);
  assign mem_we    = (state == ST_WB);
  assign mem_addr  = addr_q;
  assign mem_wdata = desc_q | (64'd1 << ABIT);

  assign rd_valid = rd_data.valid;
  assign rd_sel   = rd_data.sel;
  assign rd_base  = rd_data.base;
  assign rd_limit = rd_data.limit;
  assign rd_attr  = rd_data.attr;

  assert_mem_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_req_busy_R12: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_fault_code_R11: assert property (@(posedge clk) disable iff (rst)
    fault |-> (done && (fault_code != FC_NONE)));
  assert_no_ldt_wb_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (tgt_q != TGT_LDTR));
endmodule

// File: tb/test_seg_load_unit.sv
module test_seg_load_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        start = 0;
  logic [15:0] sel_in = 0;
  logic [2:0]  target = 0;
  logic        long_mode = 0;
  logic [31:0] gdt_base = 32'h0;
  logic [15:0] gdt_limit = 16'h00FF;
  logic        busy, done, fault;
  logic [1:0]  fault_code, cpl;
  logic [15:0] fault_sel;
  logic [2:0]  rd_target = 0;
  logic        rd_valid;
  logic [15:0] rd_sel;
  logic [31:0] rd_base, rd_limit;
  logic [11:0] rd_attr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ready = 0;
  logic [63:0] mem_rdata = 0;

  int checks = 0, failures = 0;
  int rcount = 0, wcount = 0;
  logic [63:0] mem [64];

  seg_load_unit i_seg_load_unit (
    .clk(clk), .rst(rst), .start(start), .sel_in(sel_in), .target(target),
    .long_mode(long_mode), .gdt_base(gdt_base), .gdt_limit(gdt_limit),
    .busy(busy), .done(done), .fault(fault), .fault_code(fault_code),
    .fault_sel(fault_sel), .cpl(cpl), .rd_target(rd_target), .rd_valid(rd_valid),
    .rd_sel(rd_sel), .rd_base(rd_base), .rd_limit(rd_limit), .rd_attr(rd_attr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (mem_req && !mem_ready) begin
      mem_ready = 1'b1;
      mem_rdata = mem[mem_addr[8:3]];
      if (mem_we) begin
        mem[mem_addr[8:3]] = mem_wdata;
        wcount++;
      end else rcount++;
    end else mem_ready = 1'b0;
  end

  function automatic logic [63:0] mkdesc(input logic [31:0] b, input logic [19:0] l,
      input logic [3:0] t, input logic s, input logic [1:0] dpl, input logic p,
      input logic g, input logic db);
    logic [63:0] d = '0;
    d[15:0] = l[15:0];  d[31:16] = b[15:0]; d[39:32] = b[23:16];
    d[43:40] = t; d[44] = s; d[46:45] = dpl; d[47] = p;
    d[51:48] = l[19:16]; d[54] = db; d[55] = g; d[63:56] = b[31:24];
    return d;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] s, input logic [2:0] t);
    @(negedge clk);
    sel_in = s; target = t; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 200; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("R12", "done seen", done, 1'b1);
  endtask

  task automatic rd(input logic [2:0] t);
    @(negedge clk);
    rd_target = t;
    @(negedge clk);
  endtask

  task automatic expect_fault(input string req, input logic [15:0] s, input logic [1:0] code);
    chk(req, "fault", fault, 1'b1);
    chk(req, "fault_code", fault_code, code);
    chk(req, "fault_sel", fault_sel, s);
  endtask

  task automatic t_reset;
    chk("R13", "busy", busy, 0);
    chk("R13", "done", done, 0);
    chk("R10", "cpl reset", cpl, 0);
    for (int t = 0; t < 7; t++) begin
      rd(3'(t));
      chk("R13", "valid", rd_valid, 0);
      chk("R13", "sel", rd_sel, 0);
    end
  endtask

  task automatic t_ldt_absent;
    int rc = rcount;
    load(16'h0004, 3'd2);
    expect_fault("R5", 16'h0004, 2'd1);
    chk("R5", "no read", rcount, rc);
  endtask

  task automatic t_null_data;
    int rc = rcount;
    load(16'h0003, 3'd3);
    chk("R3", "no fault", fault, 0);
    chk("R3", "no read", rcount, rc);
    rd(3'd3);
    chk("R3", "unusable", rd_valid, 0);
    chk("R3", "sel", rd_sel, 16'h0003);
  endtask

  task automatic t_code_load;
    int wc = wcount;
    logic [63:0] orig = mem[1];
    @(negedge clk);
    sel_in = 16'h0008; target = 3'd0; start = 1;
    @(negedge clk);
    start = 0;
    chk("R12", "busy after start", busy, 1);
    sel_in = 16'h0018; target = 3'd2; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 200; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("R12", "done", done, 1);
    chk("R12", "busy low at done", busy, 0);
    chk("R1", "no fault", fault, 0);
    chk("R10", "cpl", cpl, 0);
    chk("R8", "one write", wcount, wc + 1);
    chk("R8", "accessed set", mem[1], orig | (64'd1 << 40));
    rd(3'd0);
    chk("R1", "sel", rd_sel, 16'h0008);
    chk("R9", "valid", rd_valid, 1);
    chk("R9", "base", rd_base, 32'h12345678);
    chk("R9", "limit", rd_limit, 32'h000ABCDE);
    chk("R9", "attr", rd_attr, 12'h49B);
    rd(3'd2);
    chk("R12", "ignored start", rd_valid, 0);
  endtask

  task automatic t_null_code_stack;
    load(16'h0000, 3'd0);
    expect_fault("R4", 16'h0000, 2'd1);
    load(16'h0000, 3'd1);
    expect_fault("R4", 16'h0000, 2'd1);
    long_mode = 1;
    load(16'h0000, 3'd1);
    chk("R4", "null SS long", fault, 0);
    rd(3'd1);
    chk("R4", "SS unusable", rd_valid, 0);
    long_mode = 0;
  endtask

  task automatic t_stack_load;
    load(16'h0012, 3'd1);
    chk("R6", "SS ok", fault, 0);
    rd(3'd1);
    chk("R1", "sel rpl", rd_sel, 16'h0012);
    chk("R9", "base", rd_base, 32'h00100000);
    chk("R9", "granular limit", rd_limit, 32'h0000FFFF);
    chk("R9", "attr", rd_attr, 12'hC93);
  endtask

  task automatic t_type_faults;
    int wc = wcount;
    load(16'h0018, 3'd2);
    expect_fault("R6", 16'h0018, 2'd1);
    rd(3'd2);
    chk("R11", "DS unchanged", rd_sel, 16'h0000);
    load(16'h0020, 3'd3);
    expect_fault("R7", 16'h0020, 2'd2);
    load(16'h0030, 3'd1);
    expect_fault("R6", 16'h0030, 2'd1);
    rd(3'd1);
    chk("R11", "SS unchanged", rd_sel, 16'h0012);
    chk("R11", "SS base kept", rd_base, 32'h00100000);
    chk("R11", "no write on fault", wcount, wc);
    load(16'h0008, 3'd7);
    expect_fault("R6", 16'h0008, 2'd1);
  endtask

  task automatic t_ldt;
    int wc = wcount;
    load(16'h0028, 3'd6);
    chk("R6", "LDTR ok", fault, 0);
    chk("R8", "no LDTR write", wcount, wc);
    rd(3'd6);
    chk("R9", "ldt base", rd_base, 32'h00000100);
    chk("R9", "ldt limit", rd_limit, 32'h0000000F);
    chk("R9", "ldt attr", rd_attr, 12'h082);
    load(16'h0008, 3'd6);
    expect_fault("R6", 16'h0008, 2'd1);
    load(16'h002C, 3'd6);
    expect_fault("R5", 16'h002C, 2'd1);
    rd(3'd6);
    chk("R11", "LDTR kept", rd_sel, 16'h0028);
    load(16'h0004, 3'd5);
    chk("R5", "ti1 idx0", fault, 0);
    rd(3'd5);
    chk("R5", "gs base", rd_base, 32'hCAFE0000);
    chk("R9", "gs limit", rd_limit, 32'h000FFFFF);
    chk("R9", "gs attr", rd_attr, 12'h093);
  endtask

  task automatic t_bounds;
    int rc = rcount;
    load(16'h0014, 3'd5);
    expect_fault("R2", 16'h0014, 2'd1);
    chk("R2", "ldt oob no read", rcount, rc);
    load(16'h0100, 3'd2);
    expect_fault("R2", 16'h0100, 2'd1);
    chk("R2", "gdt oob no read", rcount, rc);
    load(16'h00F8, 3'd2);
    expect_fault("R2", 16'h00F8, 2'd1);
    chk("R2", "last entry read", rcount, rc + 1);
  endtask

  task automatic t_accessed_variants;
    int wc = wcount;
    logic [63:0] orig = mem[6];
    load(16'h0030, 3'd3);
    chk("R8", "ES ok", fault, 0);
    chk("R8", "ES write", wcount, wc + 1);
    chk("R8", "ES abit", mem[6], orig | (64'd1 << 40));
    load(16'h0040, 3'd4);
    chk("R8", "FS no write", wcount, wc + 1);
    load(16'h003B, 3'd0);
    chk("R10", "cpl 3", cpl, 2'd3);
    chk("R8", "CS no write", wcount, wc + 1);
    long_mode = 1;
    load(16'h0000, 3'd1);
    expect_fault("R4", 16'h0000, 2'd1);
    chk("R11", "cpl kept", cpl, 2'd3);
    long_mode = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[1]  = mkdesc(32'h12345678, 20'hABCDE, 4'hA, 1, 0, 1, 0, 1);
    mem[2]  = mkdesc(32'h00100000, 20'h0000F, 4'h2, 1, 0, 1, 1, 1);
    mem[3]  = mkdesc(32'h0, 20'hFFFFF, 4'h8, 1, 0, 1, 0, 1);
    mem[4]  = mkdesc(32'h0, 20'hFFFFF, 4'h2, 1, 0, 0, 0, 1);
    mem[5]  = mkdesc(32'h00000100, 20'h0000F, 4'h2, 0, 0, 1, 0, 0);
    mem[6]  = mkdesc(32'h0, 20'h00FFF, 4'h0, 1, 0, 1, 0, 0);
    mem[7]  = mkdesc(32'h0, 20'hFFFFF, 4'hB, 1, 3, 1, 1, 1);
    mem[8]  = mkdesc(32'h0, 20'h00FFF, 4'h3, 1, 0, 1, 0, 0);
    mem[32] = mkdesc(32'hCAFE0000, 20'hFFFFF, 4'h2, 1, 0, 1, 0, 0);
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_ldt_absent();
    t_null_data();
    t_code_load();
    t_null_code_stack();
    t_stack_load();
    t_type_faults();
    t_ldt();
    t_bounds();
    t_accessed_variants();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule